// File: doc/BRIEF.md
# Masked interrupt request aggregator

This block collects interrupt requests from up to sixteen lines into a pending register. An enable mask over the primary group of eight lines decides which pending requests may reach the processor. The block drives one level-sensitive summary interrupt. A host programs and inspects it through a byte-wide register port. The port holds two mask registers, an acknowledge register that retires one pending line, and status registers that expose the pending bits.

The mask is kept in inverted form. A host writes a 1 to block a line, and the block stores the complement as an enable bit. A read of a mask address complements the stored value again, so the host reads back what it wrote. The summary interrupt follows a tracked interrupting flag. The flag is re-evaluated only when the host writes a mask or an acknowledge. A request arriving between those writes sets its pending bit but does not raise the output by itself.

Register map (3-bit address): 0 primary mask, 1 secondary mask, 2 acknowledge, 3 pending lines 7..0, 4 secondary status, 5 pending lines 15..8. Writes take effect at the clock edge. Read data is combinational from the addressed register.

Top module: `irqagg`

## Requirements
- R1: After reset all pending bits are 0, both stored masks are 0, so a read of address 0 or 1 returns 0xFF, and irq_o is low.
- R2: A high req_i[k] in a cycle sets pending bit k at that clock edge, and the bit stays set until acknowledged. Address 3 reads pending[7:0] and address 5 reads pending[15:8].
- R3: A write to address 0 stores the bitwise inverse of the data as the primary enable mask. A read of address 0 returns the inverse of the stored mask.
- R4: After a write to address 0, irq_o is high from the next cycle if pending[7:0] AND the new enable mask is non-zero. The pending value used includes requests and acknowledges of that same cycle.
- R5: After a write to address 0 that leaves the masked pending bits zero, irq_o is low from the next cycle.
- R6: A write to address 2 clears pending bit wdata[3:0]. Data bits 7..4 are ignored and other pending bits are unchanged.
- R7: After an acknowledge, irq_o goes low if no enabled pending bit remains. Otherwise irq_o keeps its value.
- R8: When an acknowledge of line k and req_i[k] fall in the same cycle, pending bit k ends cleared.
- R9: A write to address 1 stores the data as written, and a read of address 1 returns its inverse. Neither the secondary mask nor lines 15..8 ever affect irq_o.
- R10: A read of address 4 returns 0x00.
- R11: irq_o changes only in the cycle after a write to address 0 or 2. New requests alone never change it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 16 | Interrupt request lines, sampled each clock |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i |
| irq_o | output | 1 | Summary interrupt toward the processor |

## Verification
Two pairs of functions can land on the same edge. A request can meet an acknowledge of the same line. A request can also meet a mask write that enables its line. The bench drives req_i together with the write strobe in one cycle to provoke both. It expects the acknowledged line to read back clear, and it expects the mask write to raise irq_o from the request that arrived with it. A sweep of all 256 mask values against computed pending patterns judges the summary output arithmetically.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;
  localparam int unsigned ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    ADR_MASK_PRI = 3'd0,
    ADR_MASK_SEC = 3'd1,
    ADR_ACK      = 3'd2,
    ADR_STAT_LO  = 3'd3,
    ADR_STAT_SEC = 3'd4,
    ADR_STAT_HI  = 3'd5
  } reg_addr_e;
endpackage

// File: rtl/irqagg_pending.sv
module irqagg_pending #(
  parameter int unsigned NUM_LINES = 16,
  localparam int unsigned IDX_W = $clog2(NUM_LINES)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_LINES-1:0] req_i,
  input  logic                 clr_en_i,
  input  logic [IDX_W-1:0]     clr_idx_i,
  output logic [NUM_LINES-1:0] pend_o,
  output logic [NUM_LINES-1:0] pend_nxt_o
);
  logic [NUM_LINES-1:0] pend_q;
  logic [NUM_LINES-1:0] clr_hit;

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    assign clr_hit[i]    = clr_en_i && (clr_idx_i == IDX_W'(i));
    // acknowledge wins over a same-cycle request
    assign pend_nxt_o[i] = clr_hit[i] ? 1'b0 : (pend_q[i] | req_i[i]);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pend_q[i] <= 1'b0;
      else         pend_q[i] <= pend_nxt_o[i];
    end
  end

  assign pend_o = pend_q;

  assert_ack_clears_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_en_i |=> !pend_q[$past(clr_idx_i)]);

  assert_ack_wins_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_en_i && req_i[clr_idx_i]) |=> !pend_q[$past(clr_idx_i)]);

  assert_req_sets_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((pend_q & $past(req_i & ~clr_hit)) == $past(req_i & ~clr_hit)));
endmodule

// File: rtl/irqagg_masks.sv
module irqagg_masks #(
  parameter int unsigned MASK_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pri_we_i,
  input  logic              sec_we_i,
  input  logic [MASK_W-1:0] wdata_i,
  output logic [MASK_W-1:0] pri_en_o,
  output logic [MASK_W-1:0] sec_mask_o
);
  logic [MASK_W-1:0] pri_q, sec_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pri_q <= '0;
      sec_q <= '0;
    end else begin
      if (pri_we_i) pri_q <= ~wdata_i;
      if (sec_we_i) sec_q <= wdata_i;
    end
  end

  assign pri_en_o   = pri_q;
  assign sec_mask_o = sec_q;

  assert_pri_inverted_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pri_we_i |=> (pri_q == ~$past(wdata_i)));

  assert_sec_as_written_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sec_we_i |=> (sec_q == $past(wdata_i)));
endmodule

// File: rtl/irqagg_tracker.sv
module irqagg_tracker #(
  parameter int unsigned MASK_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mask_we_i,
  input  logic [MASK_W-1:0] new_en_i,
  input  logic              ack_i,
  input  logic [MASK_W-1:0] cur_en_i,
  input  logic [MASK_W-1:0] pend_grp_i,
  input  logic [MASK_W-1:0] pend_nxt_grp_i,
  output logic              irq_o
);
  logic active_q, active_d;
  logic hit_new, hit_cur;

  assign hit_new = |(pend_nxt_grp_i & new_en_i);
  assign hit_cur = |(pend_nxt_grp_i & cur_en_i);

  always_comb begin
    active_d = active_q;
    if (mask_we_i) begin
      if (hit_new && !active_q)      active_d = 1'b1;
      else if (!hit_new && active_q) active_d = 1'b0;
    end else if (ack_i && !hit_cur) begin
      active_d = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) active_q <= 1'b0;
    else         active_q <= active_d;
  end

  assign irq_o = active_q;

  assert_irq_quiet_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mask_we_i || ack_i) |=> $stable(active_q));

  assert_irq_backed_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_q |-> |(pend_grp_i & cur_en_i));

  assert_mask_eval_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_we_i && hit_new) |=> active_q);

  assert_mask_drop_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_we_i && !hit_new) |=> !active_q);
endmodule

// File: rtl/irqagg.sv
module irqagg
  import irqagg_pkg::*;
#(
  parameter int unsigned NUM_LINES = 16,
  parameter int unsigned DATA_W    = 8,
  localparam int unsigned IDX_W    = $clog2(NUM_LINES),
  localparam int unsigned PAD_W    = 2 * DATA_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_LINES-1:0] req_i,
  input  logic                 we_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [DATA_W-1:0]    wdata_i,
  output logic [DATA_W-1:0]    rdata_o,
  output logic                 irq_o
);
  logic pri_we, sec_we, ack_we;
  logic [NUM_LINES-1:0] pend, pend_nxt;
  logic [DATA_W-1:0]    pri_en, sec_mask;
  logic [PAD_W-1:0]     pend_pad;

  assign pri_we = we_i && (addr_i == ADR_MASK_PRI);
  assign sec_we = we_i && (addr_i == ADR_MASK_SEC);
  assign ack_we = we_i && (addr_i == ADR_ACK);

  irqagg_pending #(.NUM_LINES(NUM_LINES)) u_pending (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (req_i),
    .clr_en_i   (ack_we),
    .clr_idx_i  (wdata_i[IDX_W-1:0]),
    .pend_o     (pend),
    .pend_nxt_o (pend_nxt)
  );

  irqagg_masks #(.MASK_W(DATA_W)) u_masks (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pri_we_i   (pri_we),
    .sec_we_i   (sec_we),
    .wdata_i    (wdata_i),
    .pri_en_o   (pri_en),
    .sec_mask_o (sec_mask)
  );

  irqagg_tracker #(.MASK_W(DATA_W)) u_tracker (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .mask_we_i      (pri_we),
    .new_en_i       (~wdata_i),
    .ack_i          (ack_we),
    .cur_en_i       (pri_en),
    .pend_grp_i     (pend[DATA_W-1:0]),
    .pend_nxt_grp_i (pend_nxt[DATA_W-1:0]),
    .irq_o          (irq_o)
  );

  assign pend_pad = PAD_W'(pend);

  always_comb begin
    unique case (addr_i)
      ADR_MASK_PRI: rdata_o = ~pri_en;
      ADR_MASK_SEC: rdata_o = ~sec_mask;
      ADR_STAT_LO:  rdata_o = pend_pad[DATA_W-1:0];
      ADR_STAT_HI:  rdata_o = pend_pad[PAD_W-1:DATA_W];
      default:      rdata_o = '0;
    endcase
  end

  assert_sec_status_zero_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == ADR_STAT_SEC) |-> (rdata_o == '0));
endmodule

// File: tb/irqagg_bench.sv
`timescale 1ns/1ps
module irqagg_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] req = '0;
  logic        we = 1'b0;
  logic [2:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic        irq;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  irqagg u_irqagg (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  // inputs change on the falling edge, outputs sampled there after the rising edge
  task automatic cyc(input logic w, input logic [2:0] a, input logic [7:0] d, input logic [15:0] r);
    @(negedge clk);
    we = w; addr = a; wdata = d; req = r;
    @(negedge clk);
    we = 1'b0; req = '0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    cyc(1'b1, a, d, 16'h0);
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] v);
    addr = a;
    #1 v = rdata;
  endtask

  task automatic clear_all();
    for (int k = 0; k < 16; k++) wr(3'd2, 8'(k));
  endtask

  initial begin
    #(200000 * 5);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 irq", irq, 0);
    rd(3'd0, v); chk("R1 pri mask read", v, 8'hFF);
    rd(3'd1, v); chk("R1 sec mask read", v, 8'hFF);
    rd(3'd3, v); chk("R1 pend lo", v, 0);
    rd(3'd5, v); chk("R1 pend hi", v, 0);
    rd(3'd4, v); chk("R10 sec status", v, 0);

    // sweep every primary mask value against a computed pattern
    for (int w = 0; w < 256; w++) begin
      logic [15:0] p;
      p = 16'(((w * 37 + 11) & 8'hFF) | (((w * 91 + 5) & 8'hFF) << 8));
      clear_all();
      chk("R7 irq low after clearing all", irq, 0);
      cyc(1'b0, 3'd0, 8'h0, p);
      chk("R11 request alone leaves irq", irq, 0);
      rd(3'd3, v); chk("R2 pend lo", v, p[7:0]);
      rd(3'd5, v); chk("R2 pend hi", v, p[15:8]);
      wr(3'd0, 8'(w));
      chk("R4 R5 irq after mask write", irq, int'(|(p[7:0] & ~8'(w))));
      rd(3'd0, v); chk("R3 mask readback", v, w);
    end

    // request and enabling mask write in the same cycle
    clear_all(); wr(3'd0, 8'hFF);
    cyc(1'b1, 3'd0, 8'hF7, 16'h0008);
    chk("R4 same-cycle request counted", irq, 1);
    // ack and request of the same line in the same cycle
    cyc(1'b1, 3'd2, 8'h03, 16'h0008);
    rd(3'd3, v); chk("R8 ack wins", v, 8'h00);
    chk("R7 irq dropped", irq, 0);

    // R6 upper data bits ignored, others kept
    clear_all(); wr(3'd0, 8'hFF);
    cyc(1'b0, 3'd0, 8'h0, 16'h8019);
    wr(3'd2, 8'hF3);
    rd(3'd3, v); chk("R6 only bit 3 cleared", v, 8'h11);
    rd(3'd5, v); chk("R6 high byte kept", v, 8'h80);
    wr(3'd2, 8'h0F);
    rd(3'd5, v); chk("R6 line 15 cleared", v, 8'h00);

    // R7 partial ack keeps irq
    wr(3'd0, 8'h00);
    chk("R4 irq up", irq, 1);
    wr(3'd2, 8'h00);
    chk("R7 one enabled left", irq, 1);
    wr(3'd2, 8'h04);
    chk("R7 none left", irq, 0);
    // R5 masking off drops irq
    cyc(1'b0, 3'd0, 8'h0, 16'h0002);
    wr(3'd0, 8'h00);
    chk("R4 irq up again", irq, 1);
    wr(3'd0, 8'h02);
    chk("R5 masked off", irq, 0);

    // R9 secondary mask and high lines never interrupt
    clear_all();
    wr(3'd1, 8'h00);
    rd(3'd1, v); chk("R9 sec read inverse", v, 8'hFF);
    wr(3'd1, 8'h5A);
    rd(3'd1, v); chk("R9 sec read inverse", v, 8'hA5);
    cyc(1'b0, 3'd0, 8'h0, 16'hFF00);
    wr(3'd0, 8'h00);
    chk("R9 high lines no irq", irq, 0);
    rd(3'd4, v); chk("R10 sec status zero", v, 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule